// File: doc/BRIEF.md
# Output Ramp Slew Monitor

The monitor watches the ADC codes of one supply rail while it turns on and judges whether the ramp is smooth and fast enough. Samples arrive one per fixed sample period, each qualified by a valid strobe. Software provides two values as configuration: the code that stands for the rail's nominal voltage, and the smallest acceptable code rise over one measurement window. A 5 ms window with a threshold of nominal/20 V/ms is the same as a rise of nominal/4 codes, so the comparison needs no division.

Only the part of the ramp from 10% to 90% of nominal is judged. Within that part, every sample must be higher than the one before it. For every window of `WIN_LEN` samples that lies wholly inside the part, the monitor takes the code difference between the two end samples. It keeps the smallest such difference, and reports a pass when that value meets the threshold.

The first sample at or above 90% ends the measurement and fires a one-cycle done pulse. The results then stay frozen until the next start. If the ramp never spans a full window, the result is marked invalid and does not pass.

Top module: `ramp_slew_mon`

## Requirements
- R1: With lo = floor(nominal_i/10) and hi = floor(9*nominal_i/10), the region begins with the first valid sample >= lo and < hi. It holds every following valid sample < hi (also those that fall back below lo), and it ends at the first valid sample >= hi. Samples below lo before the region are ignored.
- R2: pos_slope_o is 1 after start or reset. It clears, and stays cleared, when a region sample is less than or equal to the previous region sample.
- R3: For each region sample with index k >= WIN_LEN (index 0 is the first region sample), the window slope is s[k] - s[k-WIN_LEN]. min_slew_o is the minimum of these slopes, given as a (CODE_W+1)-bit two's complement value.
- R4: Before the first window slope, min_slew_o reads 2^CODE_W-1 and result_valid_o is 0. The first window slope sets result_valid_o to 1.
- R5: pass_o equals result_valid_o AND (signed min_slew_o >= min_rise_i).
- R6: done_o is high for exactly the one cycle after the clock edge that accepts the sample ending the region. This also happens when that sample is the first accepted sample above lo, in which case result_valid_o stays 0.
- R7: After done, further samples change no output until start_i.
- R8: start_i restores the state of R2 and R4 and re-arms the region search. A sample presented in the same cycle as start_i is ignored.
- R9: Samples with sample_valid_i low have no effect.
- R10: After reset, the outputs read pos 1, min 2^CODE_W-1, valid 0, pass 0 and done 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Clears results and re-arms the monitor |
| sample_valid_i | input | 1 | Qualifies sample_i |
| sample_i | input | CODE_W | Rail ADC code |
| nominal_i | input | CODE_W | Code of the nominal rail voltage |
| min_rise_i | input | CODE_W | Minimum required code rise per window |
| pos_slope_o | output | 1 | No non-rising step seen in the region |
| min_slew_o | output | CODE_W+1 | Smallest window rise, two's complement |
| result_valid_o | output | 1 | At least one full window was measured |
| pass_o | output | 1 | Valid and minimum rise meets threshold |
| done_o | output | 1 | One-cycle pulse at end of the region |

## Verification
If the circular buffer pointer or fill count is wrong, the window end points come out wrong. This shows in min_slew_o on the first window sample, which is WIN_LEN+1 region samples into the ramp, or at the latest on the first window whose end points differ from their neighbours. A mistake in the threshold decode moves the region start or the done pulse by at least one sample. That shift appears in the same cycle the sample is accepted. Stale state after start or after done appears as a changed output on the very next accepted sample. The bench compares every output after every sample, so such faults show up within one sample period.

// File: rtl/ramp_slew_pkg.sv
package ramp_slew_pkg;
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_RAMP  = 2'd1,
    ST_HELD  = 2'd2
  } mon_state_e;
endpackage

// File: rtl/rsm_region_fsm.sv
module rsm_region_fsm
  import ramp_slew_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              valid_i,
  input  logic [CODE_W-1:0] sample_i,
  input  logic [CODE_W-1:0] nominal_i,
  output logic              push_o,
  output logic              first_o,
  output logic              finish_o
);
  localparam int PW = CODE_W + 4;
  localparam logic [PW-1:0] TEN  = PW'(10);
  localparam logic [PW-1:0] NINE = PW'(9);

  mon_state_e state_q, state_d;
  logic [PW-1:0] nom_x, samp_x, lo_thr, hi_thr;
  logic take, at_hi, above_lo;

  always_comb begin
    nom_x    = PW'(nominal_i);
    samp_x   = PW'(sample_i);
    lo_thr   = nom_x / TEN;
    hi_thr   = (nom_x * NINE) / TEN;
    at_hi    = samp_x >= hi_thr;
    above_lo = samp_x >= lo_thr;
    take     = valid_i && !clear_i;
    push_o   = take && !at_hi &&
               ((state_q == ST_RAMP) || (state_q == ST_ARMED && above_lo));
    first_o  = push_o && (state_q == ST_ARMED);
    finish_o = take && at_hi && (state_q != ST_HELD);
  end

  always_comb begin
    state_d = state_q;
    if (clear_i)       state_d = ST_ARMED;
    else if (finish_o) state_d = ST_HELD;
    else if (first_o)  state_d = ST_RAMP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ARMED;
    else         state_q <= state_d;
  end

  assert_held_no_push_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HELD) |-> !push_o && !finish_o);
  assert_region_entry_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED && !clear_i && valid_i && samp_x < lo_thr) |=> (state_q == ST_ARMED));
endmodule

// File: rtl/rsm_win_buf.sv
module rsm_win_buf #(
  parameter int CODE_W  = 12,
  parameter int WIN_LEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              push_i,
  input  logic [CODE_W-1:0] data_i,
  output logic [CODE_W-1:0] oldest_o,
  output logic              full_o
);
  localparam int PTR_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam int CNT_W = $clog2(WIN_LEN + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(WIN_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WIN_LEN);

  logic [CODE_W-1:0] mem_q [WIN_LEN];
  logic [PTR_W-1:0]  ptr_q;
  logic [CNT_W-1:0]  fill_q;

  assign oldest_o = mem_q[ptr_q];
  assign full_o   = (fill_q == CNT_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      fill_q <= '0;
    end else if (clear_i) begin
      ptr_q  <= '0;
      fill_q <= '0;
    end else if (push_i) begin
      ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
      if (!full_o) fill_q <= fill_q + 1'b1;
    end
  end

  // storage needs no reset: reads are gated by fill count
  always_ff @(posedge clk_i) begin
    if (push_i && !clear_i) mem_q[ptr_q] <= data_i;
  end

  assert_fill_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= CNT_FULL);
  assert_ptr_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= PTR_LAST);
  assert_full_ptr_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_o && fill_q != '0) |-> (CNT_W'(ptr_q) == fill_q) || (fill_q == CNT_FULL));
endmodule

// File: rtl/rsm_slope_track.sv
module rsm_slope_track #(
  parameter int CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              push_i,
  input  logic              first_i,
  input  logic              finish_i,
  input  logic [CODE_W-1:0] sample_i,
  input  logic [CODE_W-1:0] oldest_i,
  input  logic              full_i,
  input  logic [CODE_W-1:0] min_rise_i,
  output logic              pos_slope_o,
  output logic [CODE_W:0]   min_slew_o,
  output logic              valid_o,
  output logic              pass_o,
  output logic              done_o
);
  localparam int DW = CODE_W + 1;
  localparam logic signed [DW-1:0] MIN_INIT = {1'b0, {CODE_W{1'b1}}};

  logic              pos_q, valid_q, done_q;
  logic signed [DW-1:0] min_q, diff;
  logic [CODE_W-1:0] prev_q;

  assign diff = $signed({1'b0, sample_i}) - $signed({1'b0, oldest_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= 1'b1;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      min_q   <= MIN_INIT;
      prev_q  <= '0;
    end else if (clear_i) begin
      pos_q   <= 1'b1;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      min_q   <= MIN_INIT;
      prev_q  <= '0;
    end else begin
      done_q <= finish_i;
      if (push_i) begin
        prev_q <= sample_i;
        if (!first_i && sample_i <= prev_q) pos_q <= 1'b0;
        if (full_i) begin
          valid_q <= 1'b1;
          if (diff < min_q) min_q <= diff;
        end
      end
    end
  end

  assign pos_slope_o = pos_q;
  assign min_slew_o  = min_q;
  assign valid_o     = valid_q;
  assign done_o      = done_q;
  assign pass_o      = valid_q && (min_q >= $signed({1'b0, min_rise_i}));

  assert_pos_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !pos_q) |=> !pos_q);
  assert_min_monotone_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (min_q <= $past(min_q)));
  assert_init_until_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> (min_q == MIN_INIT));
  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_hold_after_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !clear_i) |=> $stable(min_q) && $stable(pos_q) && $stable(valid_q));
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> pos_q && !valid_q && !done_q && (min_q == MIN_INIT));
endmodule

// File: rtl/ramp_slew_mon.sv
module ramp_slew_mon #(
  parameter int CODE_W  = 12,
  parameter int WIN_LEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sample_valid_i,
  input  logic [CODE_W-1:0] sample_i,
  input  logic [CODE_W-1:0] nominal_i,
  input  logic [CODE_W-1:0] min_rise_i,
  output logic              pos_slope_o,
  output logic [CODE_W:0]   min_slew_o,
  output logic              result_valid_o,
  output logic              pass_o,
  output logic              done_o
);
  logic push, first, finish, full;
  logic [CODE_W-1:0] oldest;

  rsm_region_fsm #(.CODE_W(CODE_W)) u_region (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start_i),
    .valid_i   (sample_valid_i),
    .sample_i  (sample_i),
    .nominal_i (nominal_i),
    .push_o    (push),
    .first_o   (first),
    .finish_o  (finish)
  );

  rsm_win_buf #(.CODE_W(CODE_W), .WIN_LEN(WIN_LEN)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (start_i),
    .push_i   (push),
    .data_i   (sample_i),
    .oldest_o (oldest),
    .full_o   (full)
  );

  rsm_slope_track #(.CODE_W(CODE_W)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (start_i),
    .push_i      (push),
    .first_i     (first),
    .finish_i    (finish),
    .sample_i    (sample_i),
    .oldest_i    (oldest),
    .full_i      (full),
    .min_rise_i  (min_rise_i),
    .pos_slope_o (pos_slope_o),
    .min_slew_o  (min_slew_o),
    .valid_o     (result_valid_o),
    .pass_o      (pass_o),
    .done_o      (done_o)
  );

  assert_done_after_finish_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (finish && !start_i) |=> done_o);
  assert_no_push_on_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !push && !finish);
  assert_no_push_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |-> !push && !finish);
endmodule

// File: tb/ramp_slew_mon_tb.sv
module ramp_slew_mon_tb;
  localparam int CW  = 12;
  localparam int WIN = 16;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, start = 0, svalid = 0;
  logic [CW-1:0] samp = '0, nom = '0, mrise = '0;
  logic pos, vld, pass, done;
  logic [CW:0] mslew;

  always #2.5 clk = ~clk;

  ramp_slew_mon #(.CODE_W(CW), .WIN_LEN(WIN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sample_valid_i(svalid),
    .sample_i(samp), .nominal_i(nom), .min_rise_i(mrise),
    .pos_slope_o(pos), .min_slew_o(mslew), .result_valid_o(vld),
    .pass_o(pass), .done_o(done));

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  int m_st, m_prev, m_min, m_pos, m_valid, m_done;
  int hist[$];

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void m_clear();
    m_st = 0; m_prev = 0; m_min = MAXC; m_pos = 1; m_valid = 0; m_done = 0;
    hist.delete();
  endfunction

  function automatic void m_step(int s);
    int lo, hi, n;
    lo = nom / 10;
    hi = (int'(nom) * 9) / 10;
    m_done = 0;
    if (m_st == 0) begin
      if (s >= hi) begin m_st = 2; m_done = 1; end
      else if (s >= lo) begin m_st = 1; hist.push_back(s); m_prev = s; end
    end else if (m_st == 1) begin
      if (s >= hi) begin m_st = 2; m_done = 1; end
      else begin
        if (s <= m_prev) m_pos = 0;
        m_prev = s;
        hist.push_back(s);
        n = hist.size();
        if (n > WIN) begin
          if (s - hist[n-1-WIN] < m_min) m_min = s - hist[n-1-WIN];
          m_valid = 1;
        end
      end
    end
  endfunction

  task automatic check_all(string tag);
    int ep;
    ep = (m_valid != 0 && m_min >= int'(mrise)) ? 1 : 0;
    chk({tag, " R2 pos"}, int'(pos), m_pos);
    chk({tag, " R3 min"}, int'($signed(mslew)), m_min);
    chk({tag, " R4 valid"}, int'(vld), m_valid);
    chk({tag, " R5 pass"}, int'(pass), ep);
    chk({tag, " R6 done"}, int'(done), m_done);
  endtask

  task automatic send(int s, bit v, string tag);
    @(negedge clk);
    samp = CW'(s); svalid = v;
    if (v) m_step(s); else m_done = 0;
    @(negedge clk);
    svalid = 0;
    check_all(tag);
  endtask

  task automatic do_start(int nv, int rv, bit with_sample, int s);
    @(negedge clk);
    start = 1; nom = CW'(nv); mrise = CW'(rv);
    samp = CW'(s); svalid = with_sample;
    m_clear();
    @(negedge clk);
    start = 0; svalid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int v, step, cnt;
    void'($urandom(32'd20240611));
    nom = CW'(3000); mrise = CW'(700);
    m_clear();
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 pos", int'(pos), 1);
    chk("R10 min", int'($signed(mslew)), MAXC);
    chk("R10 valid", int'(vld), 0);
    chk("R10 pass", int'(pass), 0);
    chk("R10 done", int'(done), 0);
    rst_n = 1;
    @(negedge clk);

    // R1 threshold edges, nominal 1000: lo=100, hi=900
    do_start(1000, 200, 0, 0);
    send(99, 1, "R1 below lo");
    send(100, 1, "R1 at lo");
    // R9 invalid sample above hi ignored
    send(950, 0, "R9 idle");
    chk("R9 no done", int'(done), 0);
    for (int i = 1; i <= 20; i++) send(100 + i * 30, 1, "R1 ramp");
    send(899, 1, "R1 just below hi");
    chk("R1 no done below hi", int'(done), 0);
    send(900, 1, "R1 at hi");
    chk("R1 done at hi", int'(done), 1);
    chk("R3 exact min", int'($signed(mslew)), 480);
    @(negedge clk);
    chk("R6 done one cycle", int'(done), 0);
    // R7 hold after done
    send(50, 1, "R7 after done");
    send(500, 1, "R7 after done");
    send(4000, 1, "R7 after done");
    chk("R7 no second done", int'(done), 0);

    // R6 jump straight past region: invalid
    do_start(2000, 100, 0, 0);
    send(10, 1, "R6 low");
    send(1900, 1, "R6 jump");
    chk("R6 jump invalid", int'(vld), 0);
    chk("R6 jump no pass", int'(pass), 0);

    // region shorter than one window: R4
    do_start(2000, 0, 0, 0);
    for (int i = 0; i < WIN; i++) send(200 + i * 90, 1, "R4 short");
    send(1850, 1, "R4 short end");
    chk("R4 short invalid", int'(vld), 0);
    chk("R5 short no pass", int'(pass), 0);

    // R8 start with simultaneous sample ignored
    do_start(1000, 0, 1, 500);
    chk("R8 pos", int'(pos), 1);
    chk("R8 valid", int'(vld), 0);
    chk("R8 min", int'($signed(mslew)), MAXC);
    send(150, 1, "R8 first");
    send(150, 1, "R8 flat step");
    chk("R2 flat clears", int'(pos), 0);
    send(80, 1, "R1 dip below lo stays in region");
    chk("R1 dip no done", int'(done), 0);
    do_start(1000, 0, 0, 0);
    chk("R8 pos restored", int'(pos), 1);

    // random ramps
    for (int r = 0; r < 40; r++) begin
      do_start($urandom_range(1000, 4095), $urandom_range(0, 600), 0, 0);
      v = $urandom_range(0, 80);
      cnt = 0;
      while (m_st != 2 && cnt < 3000) begin
        if ($urandom_range(0, 11) == 0) step = -$urandom_range(0, 25);
        else step = $urandom_range(4, 60);
        v = v + step;
        if (v < 0) v = 0;
        if (v > MAXC) v = MAXC;
        send(v, ($urandom_range(0, 7) != 0), "rand");
        cnt++;
      end
      for (int k = 0; k < 3; k++) send($urandom_range(0, MAXC), 1, "R7 rand hold");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule